// File: doc/BRIEF.md
# Parallel Bus Command Engine

This block turns an incoming byte stream of commands into single-byte read and write cycles on a parallel, microcontroller-style bus. The bus has three parts. One byte carries the address in the latch phase and the data in the strobe phase. A second byte holds the upper address. Three active-high strobes mark the address-latch, read and write phases. Each bus read sends back one byte on an output stream. Besides the four bus-cycle opcodes, the engine understands a flush request and two blocking commands that wait on an input pin, so pin waits and bus cycles can be mixed in one stream.

The engine listens only while its mode input holds the value 0x08. At any other value it refuses input bytes and clears to idle. A bus cycle always takes the same shape: a latch phase, then a strobe phase, then a release phase. The length of each phase in clocks is set by a parameter. An opcode the engine does not know is reported on the output stream, and the engine keeps running.

Top module: `hbe_engine`

## Requirements
- R1: `in_ready` is high only while `pin_mode` equals 0x08 and the engine is waiting for a byte. At any other mode value, bytes offered on `in_valid` produce no bus strobe and no output byte.
- R2: Opcode 0x90 followed by one address byte A runs a read cycle. During the latch phase `ad_out` shows A with `ad_oe` high and `addr_ext` shows 0x00. The byte read is then emitted once on `out_data` with `out_valid`.
- R3: Opcode 0x91 followed by bytes H then L runs a read cycle. During the latch phase `addr_ext` shows H and `ad_out` shows L.
- R4: Opcode 0x92 followed by address A and data D runs a write cycle. `ad_out` shows A in the latch phase and D in the write-strobe phase, with `ad_oe` high in both phases. Nothing is emitted on the output stream.
- R5: Opcode 0x93 followed by H, L, D runs a write cycle with `addr_ext`=H, latch address L and write data D.
- R6: Every bus cycle holds `bus_ale` for LATCH_CYC clocks, then one strobe for STROBE_CYC clocks, then no strobe for RELEASE_CYC clocks before the next byte is taken. At most one strobe is high at any time.
- R7: Opcode 0x87 raises `flush` for exactly one clock and starts no bus cycle.
- R8: Opcode 0x88 blocks input (`in_ready` low) until `wait_pin` is 1. Opcode 0x89 blocks input until `wait_pin` is 0.
- R9: Any other opcode emits 0xFA and then the opcode itself on two consecutive output clocks. After that the next opcode is accepted as normal.
- R10: After reset, all strobes, `ad_oe`, `out_valid` and `flush` are low.
- R11: Read data is sampled from `ad_in` on the last clock of the read-strobe phase. Values present earlier in that phase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_mode | input | 8 | Mode value; engine enabled at 0x08 |
| in_valid | input | 1 | Command byte offered |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Command byte taken on this clock if valid |
| wait_pin | input | 1 | Pin watched by the wait commands |
| flush | output | 1 | One-clock flush request |
| out_valid | output | 1 | Output byte present (no back-pressure) |
| out_data | output | 8 | Output byte |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| ad_out | output | 8 | Multiplexed address/data out |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_in | input | 8 | Multiplexed address/data in |
| addr_ext | output | 8 | Upper address byte during a cycle |

## Verification
The properties assume three things about the inputs: `wait_pin` is already synchronous to `clk`, `pin_mode` changes only while no command is in progress, and the output consumer never stalls, because `out_valid` has no ready signal. The stimulus follows these assumptions. It changes every input on the falling edge, sets the mode between commands only, and records each output byte on the clock in which it appears. The bench's bus model drives `ad_in` to a decoy value on every read-strobe clock except the last. This lets it confirm which clock the data is sampled on.

// File: rtl/hbe_pkg.sv
// Shared opcodes and state encodings for the parallel bus command engine.
// Assumes: opcode values are fixed by the command stream format.
package hbe_pkg;
    localparam logic [7:0] OP_FLUSH   = 8'h87;
    localparam logic [7:0] OP_WAIT_HI = 8'h88;
    localparam logic [7:0] OP_WAIT_LO = 8'h89;
    localparam logic [7:0] OP_RD_S    = 8'h90;
    localparam logic [7:0] OP_RD_X    = 8'h91;
    localparam logic [7:0] OP_WR_S    = 8'h92;
    localparam logic [7:0] OP_WR_X    = 8'h93;
    localparam logic [7:0] ERR_TAG    = 8'hFA;
    localparam logic [7:0] MODE_ON    = 8'h08;

    typedef enum logic [2:0] {
        PS_IDLE, PS_AHI, PS_ALO, PS_DATA, PS_RUN, PS_WAIT, PS_ETAG, PS_ECODE
    } pstate_t;

    typedef enum logic [1:0] {
        BP_IDLE, BP_LATCH, BP_STROBE, BP_RELEASE
    } bphase_t;
endpackage

// File: rtl/hbe_cmd_parser.sv
// Command parser: takes opcode and operand bytes, starts bus cycles,
// handles flush, pin waits and unknown-opcode reporting.
// Assumes: wait_pin synchronous to clk; 'active' low acts as a soft clear.
module hbe_cmd_parser
    import hbe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        active,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    input  logic        wait_pin,
    output logic        cyc_start,
    output logic        cyc_write,
    output logic [15:0] cyc_addr,
    output logic [7:0]  cyc_wdata,
    input  logic        cyc_done,
    output logic        flush,
    output logic        err_valid,
    output logic [7:0]  err_data
);
    pstate_t    state;
    logic [7:0] addr_hi, addr_lo, wdata, err_code;
    logic       is_wr, wait_lvl;
    logic       accept;

    // Byte acceptance: only in operand-collecting states while enabled
    always_comb begin
        in_ready = active && (state == PS_IDLE || state == PS_AHI ||
                              state == PS_ALO  || state == PS_DATA);
        accept   = in_valid && in_ready;
    end

    // Command state machine
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state     <= PS_IDLE;
            addr_hi   <= '0;
            addr_lo   <= '0;
            wdata     <= '0;
            err_code  <= '0;
            is_wr     <= 1'b0;
            wait_lvl  <= 1'b0;
            flush     <= 1'b0;
            cyc_start <= 1'b0;
        end else begin
            flush     <= 1'b0;
            cyc_start <= 1'b0;
            case (state)
                PS_IDLE: if (accept) begin
                    case (in_data)
                        OP_RD_S:    begin is_wr <= 1'b0; addr_hi <= '0; state <= PS_ALO; end
                        OP_RD_X:    begin is_wr <= 1'b0; state <= PS_AHI; end
                        OP_WR_S:    begin is_wr <= 1'b1; addr_hi <= '0; state <= PS_ALO; end
                        OP_WR_X:    begin is_wr <= 1'b1; state <= PS_AHI; end
                        OP_FLUSH:   flush <= 1'b1;
                        OP_WAIT_HI: begin wait_lvl <= 1'b1; state <= PS_WAIT; end
                        OP_WAIT_LO: begin wait_lvl <= 1'b0; state <= PS_WAIT; end
                        default:    begin err_code <= in_data; state <= PS_ETAG; end
                    endcase
                end
                PS_AHI: if (accept) begin
                    addr_hi <= in_data;
                    state   <= PS_ALO;
                end
                PS_ALO: if (accept) begin
                    addr_lo <= in_data;
                    if (is_wr) begin
                        state <= PS_DATA;
                    end else begin
                        cyc_start <= 1'b1;
                        state     <= PS_RUN;
                    end
                end
                PS_DATA: if (accept) begin
                    wdata     <= in_data;
                    cyc_start <= 1'b1;
                    state     <= PS_RUN;
                end
                PS_RUN:   if (cyc_done) state <= PS_IDLE;
                PS_WAIT:  if (wait_pin == wait_lvl) state <= PS_IDLE;
                PS_ETAG:  state <= PS_ECODE;
                PS_ECODE: state <= PS_IDLE;
                default:  state <= PS_IDLE;
            endcase
        end
    end

    // Operand and error-report outputs
    always_comb begin
        cyc_write = is_wr;
        cyc_addr  = {addr_hi, addr_lo};
        cyc_wdata = wdata;
        err_valid = (state == PS_ETAG) || (state == PS_ECODE);
        err_data  = (state == PS_ETAG) ? ERR_TAG : err_code;
    end
endmodule

// File: rtl/hbe_bus_seq.sv
// Bus cycle sequencer: one latch/strobe/release cycle per start pulse,
// phase lengths fixed by parameters; samples read data on the last strobe clock.
// Assumes: start arrives only when idle; operands stable while start is high.
module hbe_bus_seq
    import hbe_pkg::*;
#(
    parameter int LATCH_CYC   = 2,
    parameter int STROBE_CYC  = 3,
    parameter int RELEASE_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        active,
    input  logic        start,
    input  logic        is_write,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic        done,
    output logic        bus_ale,
    output logic        bus_rd,
    output logic        bus_wr,
    output logic [7:0]  ad_out,
    output logic        ad_oe,
    input  logic [7:0]  ad_in,
    output logic [7:0]  addr_ext,
    output logic        rd_valid,
    output logic [7:0]  rd_data
);
    localparam int MAX_A = (LATCH_CYC > STROBE_CYC) ? LATCH_CYC : STROBE_CYC;
    localparam int MAX_C = (MAX_A > RELEASE_CYC) ? MAX_A : RELEASE_CYC;
    localparam int CW    = $clog2(MAX_C + 1);
    localparam logic [CW-1:0] L_END = CW'(LATCH_CYC - 1);
    localparam logic [CW-1:0] S_END = CW'(STROBE_CYC - 1);
    localparam logic [CW-1:0] R_END = CW'(RELEASE_CYC - 1);

    bphase_t       phase;
    logic [CW-1:0] cnt;
    logic [15:0]   lat_addr;
    logic [7:0]    lat_wdata;
    logic          lat_wr;

    // Phase sequencing and read capture
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            phase     <= BP_IDLE;
            cnt       <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_wr    <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (phase)
                BP_IDLE: if (start) begin
                    phase     <= BP_LATCH;
                    cnt       <= '0;
                    lat_addr  <= addr;
                    lat_wdata <= wdata;
                    lat_wr    <= is_write;
                end
                BP_LATCH: begin
                    if (cnt == L_END) begin
                        phase <= BP_STROBE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                BP_STROBE: begin
                    if (cnt == S_END) begin
                        if (!lat_wr) begin
                            rd_data  <= ad_in;
                            rd_valid <= 1'b1;
                        end
                        phase <= BP_RELEASE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                BP_RELEASE: begin
                    if (cnt == R_END) begin
                        phase <= BP_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= BP_IDLE;
            endcase
        end
    end

    // Bus pin decode from phase
    always_comb begin
        bus_ale  = (phase == BP_LATCH);
        bus_rd   = (phase == BP_STROBE) && !lat_wr;
        bus_wr   = (phase == BP_STROBE) && lat_wr;
        ad_oe    = bus_ale || bus_wr;
        ad_out   = bus_ale ? lat_addr[7:0] : (bus_wr ? lat_wdata : 8'h00);
        addr_ext = (phase != BP_IDLE) ? lat_addr[15:8] : 8'h00;
        done     = (phase == BP_RELEASE) && (cnt == R_END);
    end
endmodule

// File: rtl/hbe_engine.sv
// Top of the parallel bus command engine: mode gating, parser, bus
// sequencer and the merge of read data and error reports onto one stream.
// Assumes: the output consumer accepts a byte on every clock.
module hbe_engine
    import hbe_pkg::*;
#(
    parameter int LATCH_CYC   = 2,
    parameter int STROBE_CYC  = 3,
    parameter int RELEASE_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] pin_mode,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    input  logic       wait_pin,
    output logic       flush,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       bus_ale,
    output logic       bus_rd,
    output logic       bus_wr,
    output logic [7:0] ad_out,
    output logic       ad_oe,
    input  logic [7:0] ad_in,
    output logic [7:0] addr_ext
);
    logic        active;
    logic        cyc_start, cyc_write, cyc_done;
    logic [15:0] cyc_addr;
    logic [7:0]  cyc_wdata;
    logic        err_valid, rd_valid;
    logic [7:0]  err_data, rd_data;

    // Mode gate
    always_comb active = (pin_mode == MODE_ON);

    hbe_cmd_parser u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .wait_pin  (wait_pin),
        .cyc_start (cyc_start),
        .cyc_write (cyc_write),
        .cyc_addr  (cyc_addr),
        .cyc_wdata (cyc_wdata),
        .cyc_done  (cyc_done),
        .flush     (flush),
        .err_valid (err_valid),
        .err_data  (err_data)
    );

    hbe_bus_seq #(
        .LATCH_CYC   (LATCH_CYC),
        .STROBE_CYC  (STROBE_CYC),
        .RELEASE_CYC (RELEASE_CYC)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .start    (cyc_start),
        .is_write (cyc_write),
        .addr     (cyc_addr),
        .wdata    (cyc_wdata),
        .done     (cyc_done),
        .bus_ale  (bus_ale),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .ad_in    (ad_in),
        .addr_ext (addr_ext),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // Output stream merge; sources never overlap
    always_comb begin
        out_valid = rd_valid || err_valid;
        out_data  = rd_valid ? rd_data : (err_valid ? err_data : 8'h00);
    end
endmodule

// File: rtl/hbe_engine_chk.sv
// Property checker for hbe_engine, attached by bind.
// Assumes: pin_mode changes only between commands.
module hbe_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] pin_mode,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       in_ready,
    input logic       wait_pin,
    input logic       flush,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       bus_ale,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [7:0] ad_out,
    input logic       ad_oe,
    input logic [7:0] ad_in,
    input logic [7:0] addr_ext
);
    p_ready_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> pin_mode == 8'h08);

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_ale, bus_rd, bus_wr}));

    p_latch_to_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ale) |-> (bus_rd || bus_wr));

    p_no_input_in_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale || bus_rd || bus_wr) |-> !in_ready);

    p_latch_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> ad_oe);

    p_write_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> ad_oe);

    p_read_floats_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> !ad_oe);

    p_ext_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && $past(bus_ale || bus_rd || bus_wr)) |-> $stable(addr_ext));

    p_flush_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    p_flush_no_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !(bus_ale || bus_rd || bus_wr));
endmodule

bind hbe_engine hbe_engine_chk u_chk (.*);

// File: tb/hbe_engine_test.sv
// Directed bench for hbe_engine with a bus model and output monitor.
module hbe_engine_test;
    localparam int LAT = 2;
    localparam int STB = 3;
    localparam int REL = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_mode = 8'h08;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       wait_pin = 1'b0;
    logic       flush, out_valid, bus_ale, bus_rd, bus_wr, ad_oe;
    logic [7:0] out_data, ad_out, addr_ext;
    logic [7:0] ad_in = 8'h00;

    hbe_engine #(.LATCH_CYC(LAT), .STROBE_CYC(STB), .RELEASE_CYC(REL)) uut (
        .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .wait_pin(wait_pin),
        .flush(flush), .out_valid(out_valid), .out_data(out_data),
        .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .addr_ext(addr_ext)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // monitor state
    int n_ale, n_rd, n_wr, n_rel, n_flush, out_n;
    bit gap;
    logic [7:0] lat_ad, lat_ext, wr_d, rd_good;
    bit lat_oe, wr_oe;
    logic [7:0] out_buf [0:15];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        n_ale = 0; n_rd = 0; n_wr = 0; n_rel = 0; n_flush = 0; out_n = 0; gap = 0;
        lat_ad = 0; lat_ext = 0; wr_d = 0; lat_oe = 0; wr_oe = 0;
    endtask

    // Bus model and output monitor on the falling edge
    always @(negedge clk) begin
        if (bus_ale) begin
            n_ale++; lat_ad = ad_out; lat_ext = addr_ext; lat_oe = ad_oe; gap = 0;
        end
        if (bus_rd) begin
            ad_in = (n_rd == STB - 1) ? rd_good : 8'hEE;
            n_rd++; gap = 1;
        end
        if (bus_wr) begin
            wr_d = ad_out; wr_oe = ad_oe; n_wr++; gap = 1;
        end
        if (!bus_ale && !bus_rd && !bus_wr && gap) begin
            if (in_ready) gap = 0;
            else n_rel++;
        end
        if (flush) n_flush++;
        if (out_valid && out_n < 16) begin
            out_buf[out_n] = out_data; out_n++;
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_data = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        while (!in_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!bus_ale && !bus_rd && !bus_wr, "R10 strobes", {bus_ale, bus_rd, bus_wr}, 0);
        chk(!ad_oe && !out_valid && !flush, "R10 oe/out/flush", {ad_oe, out_valid, flush}, 0);
    endtask

    task automatic t_read_short();
        clr_mon(); rd_good = 8'h5C;
        send(8'h90); send(8'h3A); settle();
        chk(n_ale == LAT, "R6 latch length", n_ale, LAT);
        chk(n_rd == STB, "R6 strobe length", n_rd, STB);
        chk(n_rel == REL, "R6 release length", n_rel, REL);
        chk(lat_ad == 8'h3A && lat_oe, "R2 latch address", lat_ad, 8'h3A);
        chk(lat_ext == 8'h00, "R2 ext address", lat_ext, 0);
        chk(out_n == 1, "R2 output count", out_n, 1);
        chk(out_buf[0] == 8'h5C, "R11 sampled on last strobe clock", out_buf[0], 8'h5C);
    endtask

    task automatic t_read_ext();
        clr_mon(); rd_good = 8'hA7;
        send(8'h91); send(8'hBE); send(8'h21); settle();
        chk(lat_ext == 8'hBE, "R3 ext address", lat_ext, 8'hBE);
        chk(lat_ad == 8'h21, "R3 latch address", lat_ad, 8'h21);
        chk(out_n == 1 && out_buf[0] == 8'hA7, "R3 read data", out_buf[0], 8'hA7);
    endtask

    task automatic t_write_short();
        clr_mon();
        send(8'h92); send(8'h44); send(8'hC3); settle();
        chk(lat_ad == 8'h44 && lat_oe, "R4 latch address", lat_ad, 8'h44);
        chk(wr_d == 8'hC3 && wr_oe, "R4 write data", wr_d, 8'hC3);
        chk(n_wr == STB && n_rd == 0, "R4 write strobe length", n_wr, STB);
        chk(out_n == 0, "R4 no output", out_n, 0);
    endtask

    task automatic t_write_ext();
        clr_mon();
        send(8'h93); send(8'h12); send(8'h34); send(8'h56); settle();
        chk(lat_ext == 8'h12, "R5 ext address", lat_ext, 8'h12);
        chk(lat_ad == 8'h34, "R5 latch address", lat_ad, 8'h34);
        chk(wr_d == 8'h56, "R5 write data", wr_d, 8'h56);
        chk(n_rel == REL, "R6 write release length", n_rel, REL);
    endtask

    task automatic t_flush();
        clr_mon();
        send(8'h87); settle();
        chk(n_flush == 1, "R7 flush pulse count", n_flush, 1);
        chk(n_ale == 0 && out_n == 0, "R7 no bus cycle", n_ale, 0);
    endtask

    task automatic t_wait();
        int hold;
        clr_mon(); wait_pin = 1'b0;
        send(8'h88);
        hold = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (in_ready) hold++;
        end
        chk(hold == 0, "R8 blocked while pin low", hold, 0);
        wait_pin = 1'b1;
        send(8'h89);
        hold = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (in_ready) hold++;
        end
        chk(hold == 0, "R8 blocked while pin high", hold, 0);
        wait_pin = 1'b0;
        rd_good = 8'h0F;
        send(8'h90); send(8'h01); settle();
        chk(out_n == 1 && out_buf[0] == 8'h0F, "R8 resumes after wait", out_buf[0], 8'h0F);
    endtask

    task automatic t_unknown();
        clr_mon();
        send(8'h8C); settle();
        chk(out_n == 2, "R9 output count", out_n, 2);
        chk(out_buf[0] == 8'hFA, "R9 tag byte", out_buf[0], 8'hFA);
        chk(out_buf[1] == 8'h8C, "R9 opcode echo", out_buf[1], 8'h8C);
        clr_mon();
        send(8'h92); send(8'h77); send(8'h99); settle();
        chk(wr_d == 8'h99, "R9 next command runs", wr_d, 8'h99);
    endtask

    task automatic t_mode_off();
        int rdy;
        clr_mon(); rdy = 0;
        @(negedge clk);
        pin_mode = 8'h02;
        in_valid = 1'b1; in_data = 8'h90;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (in_ready) rdy++;
        end
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(rdy == 0, "R1 not ready when mode off", rdy, 0);
        chk(n_ale == 0 && out_n == 0, "R1 no activity when mode off", n_ale, 0);
        pin_mode = 8'h08;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready when mode on", in_ready, 1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        clr_mon(); rd_good = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_read_short();
        t_read_ext();
        t_write_short();
        t_write_ext();
        t_flush();
        t_wait();
        t_unknown();
        t_mode_off();
        finished = 1;
        summary();
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule